// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides an input clock into a slower output whose high time and low time are each set in whole input-clock cycles. Both counts use a minus-one code, so the output period is always the sum of the two counts plus two input cycles. All of the divider's state runs on the input clock, and the output level is held in a register. Count changes made while the divider is running are held back until the current period is over, so the output never shows a short or stretched run.

A synchronous restart input puts the divider at a known phase. While restart is asserted, the output is held at a chosen start level. When restart is released, the first edge is delayed by a programmable number of input cycles. Each divider can be set to ignore restart. Only while restart is ignored can the output be forced to a steady high. A bypass setting sends the input clock straight to the output.

The reset values of the two counts are parameters. This lets different instances of the block come out of reset with different division ratios.

Top module: `duty_clk_div`

## Requirements
- R1: During reset the output is low and the start level is low. Until the first period boundary, the low and high runs use the parameter defaults DEF_LOW and DEF_HIGH (each plus one).
- R2: Outside bypass, force and restart, every low run of the output lasts exactly lowCnt+1 input cycles. lowCnt is a 4-bit value (0 to 15).
- R3: Outside bypass, force and restart, every high run lasts exactly highCnt+1 input cycles. highCnt is a 4-bit value, so 0/0 divides by two.
- R4: Count values written while running are picked up only when the output returns to its start level, which closes a full period. The period in progress finishes with the old counts.
- R5: While syncIn is 1 and noSync is 0, the output is held at the start level and the run counter is held at zero. At the same time the counts, the start level and the phase offset are captured.
- R6: startHigh=1 makes the restart level high and startHigh=0 makes it low.
- R7: After syncIn falls, the first run at the start level lasts phaseOff + N + 1 input cycles. Here phaseOff is a 4-bit value and N is the count for that level. After that first run, the output toggles normally.
- R8: With noSync=1, syncIn has no effect and the run lengths stay as in R2 and R3.
- R9: With noSync=1 and forceHigh=1, the output is a steady 1. With noSync=0, forceHigh has no effect on the output.
- R10: With bypass=1, divOut follows clkIn: it is 0 while clkIn is low and 1 while clkIn is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock to be divided |
| rstN | input | 1 | Active-low reset, synchronous to clkIn |
| syncIn | input | 1 | Synchronous restart, active high |
| lowCnt | input | CNT_W | Low-time count, in cycles minus one |
| highCnt | input | CNT_W | High-time count, in cycles minus one |
| bypass | input | 1 | Route clkIn directly to divOut |
| noSync | input | 1 | Ignore syncIn |
| forceHigh | input | 1 | Force output high (honoured only with noSync) |
| startHigh | input | 1 | Output level held during and after restart |
| phaseOff | input | PH_W | Extra input cycles before the first edge after restart |
| divOut | output | 1 | Divided clock output |

## Verification
The assertions assume that every control input changes only just after a rising edge of clkIn and is stable at the edge that samples it. They also assume that syncIn is a level held for at least one full cycle. The bench drives every input one nanosecond after a rising edge and samples the output at falling edges. This keeps the run-length and phase measurements clear of the race at the edge. Bypass and force change the output through combinational logic with no register in the path, and the bench checks them only half a cycle after it drives them.

// File: rtl/duty_clk_div_pkg.sv
package duty_clk_div_pkg;

  // Strobes from control to the datapath.
  typedef struct packed {
    logic restart;  // restart in progress: hold level, capture settings
    logic advance;  // run counter may step this cycle
  } divStrobe_t;

endpackage

// File: rtl/duty_clk_div_ctrl.sv
module duty_clk_div_ctrl
  import duty_clk_div_pkg::*;
#(
  parameter int unsigned PH_W = 4
) (
  input  logic            clkIn,
  input  logic            rstN,
  input  logic            syncIn,
  input  logic            noSync,
  input  logic [PH_W-1:0] phaseOff,
  output divStrobe_t      strobe
);

  localparam logic [PH_W-1:0] PH_ONE  = PH_W'(1);
  localparam logic [PH_W-1:0] PH_ZERO = '0;

  logic            syncActive;
  logic [PH_W-1:0] phaseCnt;

  assign syncActive = syncIn & ~noSync;

  // Phase wait counter: loaded during restart, counts down after release.
  always_ff @(posedge clkIn) begin
    if (!rstN) begin
      phaseCnt <= PH_ZERO;
    end else if (syncActive) begin
      phaseCnt <= phaseOff;
    end else if (phaseCnt != PH_ZERO) begin
      phaseCnt <= phaseCnt - PH_ONE;
    end
  end

  always_comb begin
    strobe.restart = syncActive;
    strobe.advance = ~syncActive && (phaseCnt == PH_ZERO);
  end

  // R8: an ignored restart never reaches the datapath
  a_r8_nosync_blocks: assert property (@(posedge clkIn) disable iff (!rstN)
    noSync |-> !strobe.restart);

  // R7: once released, the wait lasts no longer than the captured offset
  a_r7_wait_shrinks: assert property (@(posedge clkIn) disable iff (!rstN)
    (!strobe.restart && phaseCnt != PH_ZERO) |=>
      (strobe.restart || phaseCnt == $past(phaseCnt) - PH_ONE));

endmodule

// File: rtl/duty_clk_div_dp.sv
module duty_clk_div_dp
  import duty_clk_div_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned DEF_LOW  = 0,
  parameter int unsigned DEF_HIGH = 0
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] highCnt,
  input  logic             startHigh,
  input  logic             bypass,
  input  logic             noSync,
  input  logic             forceHigh,
  output logic             divOut
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] RST_LOW  = CNT_W'(DEF_LOW);
  localparam logic [CNT_W-1:0] RST_HIGH = CNT_W'(DEF_HIGH);

  logic             outLvl;
  logic             startSh;
  logic [CNT_W-1:0] runCnt;
  logic [CNT_W-1:0] lowSh;
  logic [CNT_W-1:0] highSh;
  logic [CNT_W-1:0] curLim;
  logic             runEnd;
  logic             periodEnd;

  assign curLim    = outLvl ? highSh : lowSh;
  assign runEnd    = strobe.advance && (runCnt == curLim);
  assign periodEnd = runEnd && ((~outLvl) == startSh);

  // Level register and run counter
  always_ff @(posedge clkIn) begin
    if (!rstN) begin
      outLvl <= 1'b0;
      runCnt <= '0;
    end else if (strobe.restart) begin
      outLvl <= startHigh;
      runCnt <= '0;
    end else if (runEnd) begin
      outLvl <= ~outLvl;
      runCnt <= '0;
    end else if (strobe.advance) begin
      runCnt <= runCnt + CNT_ONE;
    end
  end

  // Shadow settings: taken at restart or at the close of a period
  always_ff @(posedge clkIn) begin
    if (!rstN) begin
      lowSh   <= RST_LOW;
      highSh  <= RST_HIGH;
      startSh <= 1'b0;
    end else if (strobe.restart) begin
      lowSh   <= lowCnt;
      highSh  <= highCnt;
      startSh <= startHigh;
    end else if (periodEnd) begin
      lowSh   <= lowCnt;
      highSh  <= highCnt;
    end
  end

  // Output selection: bypass routes the input clock through
  always_comb begin
    if (bypass)                divOut = clkIn;
    else if (noSync && forceHigh) divOut = 1'b1;
    else                       divOut = outLvl;
  end

  // R5: restart puts the level at the requested start value
  a_r5_restart_level: assert property (@(posedge clkIn) disable iff (!rstN)
    strobe.restart |=> (outLvl == $past(startHigh)) && (runCnt == '0));

  // R2: a low run never counts past its limit
  a_r2_low_bound: assert property (@(posedge clkIn) disable iff (!rstN)
    !outLvl |-> runCnt <= lowSh);

  // R3: a high run never counts past its limit
  a_r3_high_bound: assert property (@(posedge clkIn) disable iff (!rstN)
    outLvl |-> runCnt <= highSh);

  // R4: with the counter stalled, the captured counts do not move
  a_r4_counts_hold: assert property (@(posedge clkIn) disable iff (!rstN)
    (!strobe.restart && !strobe.advance) |=> $stable(lowSh) && $stable(highSh));

  // R7: during the phase wait the level stays put
  a_r7_wait_level: assert property (@(posedge clkIn) disable iff (!rstN)
    (!strobe.restart && !strobe.advance) |=> $stable(outLvl));

endmodule

// File: rtl/duty_clk_div.sv
module duty_clk_div
  import duty_clk_div_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned PH_W     = 4,
  parameter int unsigned DEF_LOW  = 0,
  parameter int unsigned DEF_HIGH = 0
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic             syncIn,
  input  logic [CNT_W-1:0] lowCnt,
  input  logic [CNT_W-1:0] highCnt,
  input  logic             bypass,
  input  logic             noSync,
  input  logic             forceHigh,
  input  logic             startHigh,
  input  logic [PH_W-1:0]  phaseOff,
  output logic             divOut
);

  divStrobe_t strobe;

  duty_clk_div_ctrl #(.PH_W(PH_W)) u_ctrl (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .syncIn   (syncIn),
    .noSync   (noSync),
    .phaseOff (phaseOff),
    .strobe   (strobe)
  );

  duty_clk_div_dp #(
    .CNT_W    (CNT_W),
    .DEF_LOW  (DEF_LOW),
    .DEF_HIGH (DEF_HIGH)
  ) u_dp (
    .clkIn     (clkIn),
    .rstN      (rstN),
    .strobe    (strobe),
    .lowCnt    (lowCnt),
    .highCnt   (highCnt),
    .startHigh (startHigh),
    .bypass    (bypass),
    .noSync    (noSync),
    .forceHigh (forceHigh),
    .divOut    (divOut)
  );

endmodule

// File: tb/duty_clk_div_tb.sv
`timescale 1ns/1ps
module duty_clk_div_tb;

  localparam int DEF_L = 2;
  localparam int DEF_H = 2;

  logic       clkIn = 1'b0;
  logic       rstN, syncIn, bypass, noSync, forceHigh, startHigh;
  logic [3:0] lowCnt, highCnt, phaseOff;
  logic       divOut;

  int  checks = 0;
  int  errors = 0;
  logic curSample;

  always #2.5 clkIn = ~clkIn;

  duty_clk_div #(.CNT_W(4), .PH_W(4), .DEF_LOW(DEF_L), .DEF_HIGH(DEF_H)) u_dut (
    .clkIn(clkIn), .rstN(rstN), .syncIn(syncIn), .lowCnt(lowCnt),
    .highCnt(highCnt), .bypass(bypass), .noSync(noSync),
    .forceHigh(forceHigh), .startHigh(startHigh), .phaseOff(phaseOff),
    .divOut(divOut)
  );

  function automatic int expRun(logic lvl, int l, int h);
    return (lvl ? h : l) + 1;
  endfunction

  function automatic int expFirst(int ph, logic lvl, int l, int h);
    return ph + expRun(lvl, l, h);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measure the run that starts with the current sample (taken at negedges).
  task automatic nextRun(output int len, output logic lvl);
    lvl = curSample;
    len = 0;
    while (curSample == lvl) begin
      len++;
      @(negedge clkIn);
      curSample = divOut;
    end
  endtask

  // Restart: hold syncIn for n cycles and check the held level, then release.
  task automatic doSync(int n);
    @(posedge clkIn); #1 syncIn = 1'b1;
    @(posedge clkIn);
    for (int i = 0; i < n; i++) begin
      @(negedge clkIn);
      check(divOut == startHigh, "R5 hold level", divOut, startHigh);
    end
    @(posedge clkIn); #1 syncIn = 1'b0;
    @(negedge clkIn);
    curSample = divOut;
    check(curSample == startHigh, "R6 start level", curSample, startHigh);
  endtask

  task automatic runCheck(int l, int h, string req);
    int len; logic lvl;
    nextRun(len, lvl);
    check(len == expRun(lvl, l, h), req, len, expRun(lvl, l, h));
  endtask

  task automatic restartCheck(int l, int h, int ph, int nRuns);
    int len; logic lvl;
    lowCnt = 4'(l); highCnt = 4'(h); phaseOff = 4'(ph);
    doSync(2);
    nextRun(len, lvl);
    check(len == expFirst(ph, startHigh, l, h), "R7 first run", len,
          expFirst(ph, startHigh, l, h));
    for (int k = 0; k < nRuns; k++) begin
      nextRun(len, lvl);
      check(len == expRun(lvl, l, h), lvl ? "R3 high run" : "R2 low run",
            len, expRun(lvl, l, h));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clkIn);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int len; logic lvl;
    void'($urandom(32'h5eed_c10c));
    rstN = 1'b0; syncIn = 1'b0; bypass = 1'b0; noSync = 1'b0;
    forceHigh = 1'b0; startHigh = 1'b0; phaseOff = '0;
    lowCnt = 4'd5; highCnt = 4'd6;
    repeat (3) @(posedge clkIn);
    @(negedge clkIn);
    check(divOut == 1'b0, "R1 reset low", divOut, 0);
    @(posedge clkIn); #1 rstN = 1'b1;
    @(negedge clkIn); curSample = divOut;
    // R1: runs from the parameter defaults, then R4 loads 5/6 at boundary
    nextRun(len, lvl);
    check(len == DEF_L + 1 && !lvl, "R1 default low", len, DEF_L + 1);
    nextRun(len, lvl);
    check(len == DEF_H + 1 && lvl, "R1 default high", len, DEF_H + 1);
    runCheck(5, 6, "R4 loaded low");
    runCheck(5, 6, "R4 loaded high");
    // R4: change mid low run; the current period keeps 5/6
    lowCnt = 4'd9; highCnt = 4'd3;
    runCheck(5, 6, "R4 old low");
    runCheck(5, 6, "R4 old high");
    runCheck(9, 3, "R4 new low");
    runCheck(9, 3, "R4 new high");

    // R2/R3/R6: every count pair, random start level
    for (int l = 0; l < 16; l++) begin
      for (int h = 0; h < 16; h++) begin
        startHigh = 1'($urandom % 2);
        restartCheck(l, h, 0, 3);
      end
    end

    // R7: every phase offset, both start levels
    for (int ph = 0; ph < 16; ph++) begin
      startHigh = 1'(ph % 2);
      restartCheck(3, 1, ph, 2);
    end

    // Random mixes
    for (int t = 0; t < 24; t++) begin
      startHigh = 1'($urandom % 2);
      restartCheck(int'($urandom % 16), int'($urandom % 16),
                   int'($urandom % 16), 3);
    end

    // R8: syncIn ignored with noSync set
    startHigh = 1'b0;
    restartCheck(3, 4, 0, 1);
    noSync = 1'b1; syncIn = 1'b1;
    for (int k = 0; k < 4; k++) runCheck(3, 4, "R8 sync ignored");
    syncIn = 1'b0; noSync = 1'b0;

    // R9: force without noSync has no effect
    forceHigh = 1'b1;
    for (int k = 0; k < 3; k++) runCheck(3, 4, "R9 force ignored");
    @(posedge clkIn); #1 noSync = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clkIn);
      check(divOut == 1'b1, "R9 forced high", divOut, 1);
    end
    @(posedge clkIn); #1 forceHigh = 1'b0; noSync = 1'b0;

    // R10: bypass follows the input clock
    @(posedge clkIn); #1 bypass = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clkIn); #1;
      check(divOut == 1'b0, "R10 bypass low phase", divOut, 0);
      @(posedge clkIn); #1;
      check(divOut == 1'b1, "R10 bypass high phase", divOut, 1);
    end
    bypass = 1'b0;
    restartCheck(2, 5, 1, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule